// File: doc/BRIEF.md
# Run-Length Capture Stream Decoder

This block turns the compressed word stream of a change-only capture buffer back into a plain sample stream, one sample per accepted output beat. Every incoming word has a type bit at the top. With the type bit clear, the remaining bits are a fresh sample: it is sent out once and kept as the held sample. With the type bit set, the remaining bits are a repeat count, and the held sample is sent out that many more times.

Both sides use a valid/ready handshake. A word is taken only while no repeat is still being played out and the output register is free or draining, so a repeat word costs one input cycle and then drives as many output beats as its count. Three sticky flags report stream anomalies: a repeat before any fresh sample (played out as zeros), a repeat count at the encoder's all-ones ceiling (real length unknown), and two repeat words in a row (both counts are played out as one longer run). A synchronous reset clears everything.

Top module: `rle_sample_expander`

## Requirements
- R1: While and right after reset, outValid, unknownStart, runSaturated and protoError are 0 and inReady is 1.
- R2: A word with bit WORD_W-1 clear is a fresh sample: its bits WORD_W-2..0 appear on outSample in the cycle after it is taken, exactly once, and become the held sample.
- R3: A word with bit WORD_W-1 set and count N in bits WORD_W-2..0 makes the held sample appear for N accepted output beats in a row, and inReady stays low until the last of them is presented.
- R4: While outValid is high and outReady is low, outValid and outSample hold, no beat is lost or added, and inReady is low.
- R5: A repeat word taken before any fresh sample since reset plays out zeros and sets unknownStart.
- R6: A repeat word whose count is all ones sets runSaturated in the cycle after it is taken.
- R7: A repeat word taken directly after another repeat word sets protoError, and the held sample continues for the sum of both counts.
- R8: The three flags stay set until reset, and reset clears them.
- R9: A repeat word with count 0 produces no output beat.
- R10: With outReady held high, fresh-sample words are taken one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Compressed word offered |
| inWord | input | WORD_W | Compressed word: top bit type, rest payload |
| inReady | output | 1 | Decoder takes the offered word this cycle |
| outValid | output | 1 | Expanded sample present |
| outSample | output | WORD_W-1 | Expanded sample |
| outReady | input | 1 | Consumer takes the sample this cycle |
| unknownStart | output | 1 | Sticky: repeat seen before any fresh sample |
| runSaturated | output | 1 | Sticky: repeat count hit the all-ones ceiling |
| protoError | output | 1 | Sticky: two repeat words in a row |

## Verification
The properties assume that inWord is stable whenever it is sampled with inValid high and that reset lasts at least two cycles, so the sticky flags start from a cleared value. The stimulus changes inputs only at the falling edge and holds reset for three cycles. Random streams are produced by compressing slowly changing sample sequences the way the capture side does, so they never hold back-to-back repeats or saturated counts; those two cases, a leading repeat and a zero count are driven only in directed steps, with the output stalled at chosen points.

// File: rtl/rle_expand_pkg.sv
package rle_expand_pkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic takeLit;   // fresh sample word taken
    logic takeRun;   // repeat word taken
    logic stepRun;   // one repeat beat consumed while more remain
  } rleStrobe_t;
endpackage

// File: rtl/rle_expand_ctrl.sv
module rle_expand_ctrl
  import rle_expand_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  input  logic              outReady,
  input  logic              runIdle,
  output logic              outValid,
  output rleStrobe_t        strb,
  output logic              unknownStart,
  output logic              runSaturated,
  output logic              protoError
);
  localparam int SAMPLE_W = WORD_W - 1;

  logic isRun, runEmpty, runFull, accept, fire;
  logic litSeen, lastRun;

  assign isRun    = inWord[WORD_W-1];
  assign runEmpty = (inWord[SAMPLE_W-1:0] == '0);
  assign runFull  = &inWord[SAMPLE_W-1:0];
  assign fire     = outValid && outReady;
  assign inReady  = runIdle && (!outValid || outReady);
  assign accept   = inValid && inReady;

  always_comb begin
    strb.takeLit = accept && !isRun;
    strb.takeRun = accept && isRun;
    strb.stepRun = fire && !runIdle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else if (strb.takeLit) begin
      outValid <= 1'b1;
    end else if (strb.takeRun) begin
      outValid <= !runEmpty;
    end else if (fire && runIdle) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      litSeen      <= 1'b0;
      lastRun      <= 1'b0;
      unknownStart <= 1'b0;
      runSaturated <= 1'b0;
      protoError   <= 1'b0;
    end else begin
      if (accept) lastRun <= isRun;
      if (strb.takeLit) litSeen <= 1'b1;
      if (strb.takeRun && !litSeen) unknownStart <= 1'b1;
      if (strb.takeRun && runFull) runSaturated <= 1'b1;
      if (strb.takeRun && lastRun) protoError <= 1'b1;
    end
  end

  AST_SAT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (strb.takeRun && runFull) |=> runSaturated); // R6
  AST_UNK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(unknownStart)); // R8
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(runSaturated)); // R8
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(protoError)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.takeLit, strb.takeRun, strb.stepRun})); // R3
endmodule

// File: rtl/rle_expand_dp.sv
module rle_expand_dp
  import rle_expand_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   inWord,
  input  rleStrobe_t          strb,
  output logic                runIdle,
  output logic [WORD_W-2:0]   outSample
);
  localparam int SAMPLE_W = WORD_W - 1;

  logic [SAMPLE_W-1:0] payload, holdVal, remain;

  assign payload = inWord[SAMPLE_W-1:0];
  assign runIdle = (remain == '0);

  // Beats still to be presented after the one in the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (strb.takeRun) begin
      remain <= (payload == '0) ? '0 : payload - 1'b1;
    end else if (strb.stepRun) begin
      remain <= remain - 1'b1;
    end
  end

  // Held sample resets to zero, so a leading repeat plays out zeros.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdVal   <= '0;
      outSample <= '0;
    end else if (strb.takeLit) begin
      holdVal   <= payload;
      outSample <= payload;
    end else if (strb.takeRun) begin
      outSample <= holdVal;
    end
  end

  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strb.stepRun |-> !runIdle); // R3
endmodule

// File: rtl/rle_sample_expander.sv
module rle_sample_expander
  import rle_expand_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              outValid,
  output logic [WORD_W-2:0] outSample,
  input  logic              outReady,
  output logic              unknownStart,
  output logic              runSaturated,
  output logic              protoError
);
  rleStrobe_t strb;
  logic       runIdle;

  rle_expand_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outReady(outReady), .runIdle(runIdle),
    .outValid(outValid), .strb(strb), .unknownStart(unknownStart),
    .runSaturated(runSaturated), .protoError(protoError)
  );

  rle_expand_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst(rst), .inWord(inWord), .strb(strb),
    .runIdle(runIdle), .outSample(outSample)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outSample))); // R4
  AST_LIT_OUT: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !inWord[WORD_W-1]) |=>
      (outValid && outSample == $past(inWord[WORD_W-2:0]))); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !runIdle |-> (outValid && !inReady)); // R3
  AST_UNK_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(unknownStart) && outValid) |-> (outSample == '0)); // R5
endmodule

// File: tb/rle_sample_expander_tb_top.sv
module rle_sample_expander_tb_top;
  localparam int WORD_W = 32;
  localparam int SW = WORD_W - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [WORD_W-1:0] inWord = '0;
  logic inReady, outValid, unknownStart, runSaturated, protoError;
  logic [SW-1:0] outSample;

  rle_sample_expander #(.WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outSample(outSample),
    .outReady(outReady), .unknownStart(unknownStart),
    .runSaturated(runSaturated), .protoError(protoError)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int stallPct = 0;
  bit forceStall = 0, monOff = 0;
  logic [SW-1:0] expQ[$];
  logic [SW-1:0] refHold = '0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // Monitor: chooses outReady, pops and compares each beat.
  initial begin
    forever begin
      @(negedge clk);
      outReady = forceStall ? 1'b0 : ($urandom_range(99) >= stallPct);
      #2;
      if (!monOff && !rst && outValid && outReady) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 extra beat: got %h expected none", outSample);
        end else begin
          chk("R2/R3 scoreboard sample", 32'(outSample), 32'(expQ.pop_front()));
        end
      end
    end
  end

  task automatic sendWord(logic [WORD_W-1:0] w);
    inValid = 1'b1;
    inWord  = w;
    do begin
      @(negedge clk); #5;
    end while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  // Driver with reference model: pushes expected beats, then sends.
  task automatic feedLit(logic [SW-1:0] v);
    expQ.push_back(v);
    refHold = v;
    sendWord({1'b0, v});
  endtask

  task automatic feedRun(logic [SW-1:0] n);
    for (int i = 0; i < int'(n); i++) expQ.push_back(refHold);
    sendWord({1'b1, n});
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    refHold = '0;
    expQ.delete();
  endtask

  initial begin
    int c0;
    doReset();
    // R1
    @(negedge clk); #5;
    chk("R1 outValid", 32'(outValid), 0);
    chk("R1 flags", {29'd0, unknownStart, runSaturated, protoError}, 0);
    chk("R1 inReady", 32'(inReady), 1);
    @(posedge clk); #1;

    // R5: leading repeat plays zeros
    feedRun(31'd3);
    drain();
    chk("R5 unknownStart", 32'(unknownStart), 1);

    // R2 / R3
    feedLit(31'h55);
    feedRun(31'd5);
    @(negedge clk); #5;
    chk("R3 inReady low during run", 32'(inReady), 0);
    drain();
    chk("R7 no protoError yet", 32'(protoError), 0);

    // R4: stall mid run
    feedLit(31'h12);
    feedRun(31'd6);
    forceStall = 1;
    begin
      bit held = 1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #5;
        if (!(outValid && outSample == 31'h12 && !inReady)) held = 0;
      end
      chk("R4 stalled output holds", 32'(held), 1);
    end
    forceStall = 0;
    drain();
    chk("R4 no beat lost", 32'(expQ.size()), 0);

    // R7: back-to-back repeats add
    feedLit(31'h7);
    feedRun(31'd2);
    feedRun(31'd3);
    drain();
    chk("R7 protoError", 32'(protoError), 1);

    // R9: zero count emits nothing (scoreboard flags extras)
    feedLit(31'h9);
    feedRun(31'd0);
    feedLit(31'hA);
    drain();
    chk("R9 queue empty", 32'(expQ.size()), 0);

    // R10: one literal per cycle
    feedLit(31'h100);
    c0 = cyc;
    for (int i = 1; i <= 8; i++) feedLit(31'(i + 'h100));
    chk("R10 cycles for 8 literals", 32'(cyc - c0), 8);
    drain();

    // R6: saturated count
    feedLit(31'h3C);
    drain();
    monOff = 1;
    sendWord({1'b1, {SW{1'b1}}});
    chk("R6 runSaturated", 32'(runSaturated), 1);
    chk("R6 held sample repeats", 32'(outSample), 32'h3C);
    chk("R8 unknownStart still set", 32'(unknownStart), 1);
    doReset();
    monOff = 0;
    @(negedge clk); #5;
    chk("R8 flags cleared by reset", {29'd0, unknownStart, runSaturated, protoError}, 0);
    chk("R1 outValid after reset", 32'(outValid), 0);
    @(posedge clk); #1;

    // Random compressed streams with output stalls (R2 R3 R4)
    stallPct = 30;
    for (int r = 0; r < 4; r++) begin
      logic [SW-1:0] cur;
      logic [SW-1:0] run;
      doReset();
      cur = 31'($urandom);
      run = '0;
      expQ.push_back(cur);
      sendWord({1'b0, cur});
      for (int k = 1; k < 300; k++) begin
        logic [SW-1:0] nxt;
        nxt = cur;
        if ($urandom_range(4) == 0) begin
          nxt = 31'($urandom);
          if (nxt == cur) nxt = cur + 1'b1;
        end
        expQ.push_back(nxt);
        if (nxt == cur) begin
          run++;
        end else begin
          if (run != 0) sendWord({1'b1, run});
          run = '0;
          sendWord({1'b0, nxt});
          cur = nxt;
        end
      end
      if (run != 0) sendWord({1'b1, run});
      drain();
      chk("R3 random stream drained", 32'(expQ.size()), 0);
      chk("R7 random stream no protoError", 32'(protoError), 0);
    end

    summary();
    $finish;
  end
endmodule